// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block makes a chip answer on a two-wire serial bus the way a small serial EEPROM does. It oversamples the clock line (SCL) and the data line (SDA) with the system clock through two-flop synchronizers. It finds START and STOP conditions and the rising and falling edges of SCL in the system clock domain. It reaches the data line only through a pull-down enable, so an external pad makes it open-drain. The storage is a register array of 256 bytes by default; with `ADDR_W = 7` it holds 128 bytes. An internal word pointer sets where reads start and where writes land. A write-protect input freezes the whole array.

A master first sends a device byte after START. If that byte matches, the master can send a word address and one data byte (byte write), send only a word address and then a repeated START (random read), or read straight away from the pointer (current-address read). A read keeps streaming bytes for as long as the master acknowledges them (sequential read).

The controller has ten states. ST_IDLE waits for START. ST_DEV takes in the device byte. ST_DEV_ACK holds the acknowledge for it. ST_WADDR and ST_WADDR_ACK take in and acknowledge the word address. ST_WDATA and ST_WDATA_ACK take in, store and acknowledge the data byte. ST_RDATA shifts a byte out. ST_RACK samples the master's acknowledge. ST_HOLD stays off the line until START or STOP.

The transitions are as follows. STOP leads from any state to ST_IDLE. START leads from any state to ST_DEV. The falling SCL edge after the eighth bit is the point where a byte ends. At that point ST_DEV goes to ST_DEV_ACK on a match and to ST_IDLE on a mismatch, ST_WADDR goes to ST_WADDR_ACK, ST_WDATA goes to ST_WDATA_ACK, and ST_RDATA goes to ST_RACK. The falling SCL edge that ends the ninth clock moves the acknowledge states on. ST_DEV_ACK goes to ST_RDATA when the R/W bit is 1 and to ST_WADDR when it is 0. ST_WADDR_ACK goes to ST_WDATA. ST_WDATA_ACK goes to ST_HOLD. ST_RACK goes to ST_RDATA when the master acknowledged and to ST_HOLD when it did not.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a new transaction from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle. In idle the block never pulls SDA, and SCL clocks without a START get no acknowledge.
- R2: Bytes are 8 bits, most significant bit first, and are sampled on SCL rising edges. The first byte after START is the device byte. Its bits 7:4 must be 1010, its bits 3:1 must equal `dev_strap_i[2:0]`, and its bit 0 is R/W (0 = write, 1 = read). On a match the block pulls SDA low through the ninth clock. On a mismatch it leaves SDA released for that acknowledge and for every later bit until the next START.
- R3: In a write transaction the byte after the device byte is the word address. It is acknowledged, and its low `ADDR_W` bits load the pointer.
- R4: The byte after the word address is a data byte. It is acknowledged and, with `wp_i` low, stored at the pointer. The pointer then advances by one.
- R5: With `wp_i` high, the data byte is still acknowledged and the pointer still advances, but the array keeps its old contents.
- R6: Any byte after the first data byte of a write is not acknowledged and is not stored, and it leaves the pointer unchanged.
- R7: In a read transaction the block sends the byte at the pointer and advances the pointer. The pointer wraps from the last location to 0. A read that directly follows START and the device byte starts at the current pointer.
- R8: A write transaction that carries only a word address, followed by a repeated START and a read, returns the byte at that word address.
- R9: While the master acknowledges, bytes follow one after another from successive addresses. After a non-acknowledge the block releases SDA and sends nothing more until START or STOP.
- R10: The block only ever pulls SDA low (`sda_pull_o` = 1) or releases it. Outgoing bits and acknowledges change only while SCL is low.
- R11: After reset the block is idle with SDA released, the pointer is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_strap_i | input | 3 | Strapped device-select bits compared with device byte bits 3:1 |
| wp_i | input | 1 | Write protect; 1 freezes the array |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A corrupted bit counter moves the acknowledge by one SCL clock. The master's sample in the ninth clock shows this at once, in the same byte. A wrong pointer, or a pointer that fails to advance or to wrap, is only visible on the next byte read out, which can be one transaction later. That is why every write is followed by a read of the same and of the neighbouring locations. A controller stuck in a receive or send state instead of ST_HOLD or ST_IDLE shows as a low SDA during bits where the line must stay high. The bench therefore clocks extra bytes after a mismatch, after a non-acknowledge and without a START, and expects all ones.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } ee_state_e;

endpackage

// File: rtl/i2c_ee_line_sync.sv
module i2c_ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_d    <= scl_pipe[LAST];
            sda_d    <= sda_pipe[LAST];
        end
    end

    assign scl_o      = scl_pipe[LAST];
    assign sda_o      = sda_pipe[LAST];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    // data line moves while the clock line stays high on both samples
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en_i && !wp_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    // R4: an unprotected store lands in the addressed location
    p_store_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && !$past(wp_i)) |-> (mem[$past(wr_addr_i)] == $past(wr_data_i)));

    // R5: a protected store leaves the addressed location untouched
    p_protect_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && $past(wp_i)) |-> (mem[$past(wr_addr_i)] == $past(mem[wr_addr_i])));

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);

    localparam logic [ADDR_W-1:0] PTR_STEP = 1;
    localparam logic [3:0]        LAST_BIT = 4'd8;

    ee_state_e           state, state_nxt;
    logic                scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]          bit_cnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [ADDR_W-1:0]   ptr;
    logic                master_ack;
    logic                counting;
    logic                byte_end;
    logic                dev_hit;
    logic                wr_en;
    logic [BYTE_W-1:0]   rd_data;

    i2c_ee_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_ee_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_i      (wp_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (ptr),
        .wr_data_i (rx_sh),
        .rd_addr_i (ptr),
        .rd_data_o (rd_data)
    );

    assign counting = (state == ST_DEV) || (state == ST_WADDR) ||
                      (state == ST_WDATA) || (state == ST_RDATA);
    assign byte_end = scl_fall && (bit_cnt == LAST_BIT);
    assign dev_hit  = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == dev_strap_i);
    assign wr_en    = (state == ST_WDATA) && (state_nxt == ST_WDATA_ACK);

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (stop_det) begin
            state_nxt = ST_IDLE;
        end else if (start_det) begin
            state_nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:      state_nxt = ST_IDLE;
                ST_DEV:       if (byte_end) state_nxt = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_nxt = rx_sh[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_end) state_nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_nxt = ST_WDATA;
                ST_WDATA:     if (byte_end) state_nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nxt = ST_HOLD;
                ST_RDATA:     if (byte_end) state_nxt = ST_RACK;
                ST_RACK:      if (scl_fall) state_nxt = master_ack ? ST_RDATA : ST_HOLD;
                ST_HOLD:      state_nxt = ST_HOLD;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // bit counter, shifters and word pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '1;
            ptr        <= '0;
            master_ack <= 1'b0;
        end else begin
            if (start_det || (state_nxt != state)) begin
                bit_cnt <= '0;
            end else if (scl_rise && counting) begin
                bit_cnt <= bit_cnt + 4'd1;
            end

            if (scl_rise && counting && (state != ST_RDATA)) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
            end

            if (scl_rise && (state == ST_RACK)) begin
                master_ack <= ~sda_s;
            end

            if ((state_nxt == ST_RDATA) && (state != ST_RDATA)) begin
                tx_sh <= rd_data;
                ptr   <= ptr + PTR_STEP;
            end else if ((state == ST_RDATA) && scl_fall && (state_nxt == ST_RDATA)) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            end

            if ((state == ST_WADDR) && (state_nxt == ST_WADDR_ACK)) begin
                ptr <= rx_sh[ADDR_W-1:0];
            end else if (wr_en) begin
                ptr <= ptr + PTR_STEP;
            end
        end
    end

    // line output: pull low for acknowledges and for zero data bits
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                               sda_pull_o = ~tx_sh[BYTE_W-1];
            default:                                sda_pull_o = 1'b0;
        endcase
    end

    // R1: the line is free right after a STOP
    p_free_after_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull_o);

    // R2: an acknowledge of the device byte only follows a matching byte
    p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> ((rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == dev_strap_i)));

    // R2: no field runs past eight bits
    p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);

    // R10: the pull stays put during a high clock phase outside START/STOP
    p_pull_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull_o));

endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] dev_strap = 3'b101;
    logic       wp = 1'b0;
    logic       sda_pull;
    wire        sda_line = m_sda & ~sda_pull;

    int         n_checks = 0;
    int         n_fail = 0;
    int         hi_changes = 0;
    logic       scl_prev = 1'b1;
    logic       pull_prev = 1'b0;
    logic [7:0] mdl [256];
    int         mptr = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_target u_i2c_eeprom_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .dev_strap_i (dev_strap),
        .wp_i        (wp),
        .sda_pull_o  (sda_pull)
    );

    // R10 monitor: pull must not move while the clock line stays high
    always @(negedge clk) begin
        if (rst_n && scl_prev && m_scl && (sda_pull != pull_prev)) hi_changes++;
        scl_prev  <= m_scl;
        pull_prev <= sda_pull;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic s);
        m_sda = b;  wq();
        m_scl = 1'b1; wq();
        s = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic tx_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic rx_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d, input string req);
        logic k0, k1, k2;
        i2c_start();
        tx_byte(8'hAA, k0);
        tx_byte(a, k1);
        tx_byte(d, k2);
        i2c_stop();
        chk(k0 && k1 && k2, req, {k0, k1, k2}, 3'b111);
        if (!wp) mdl[a] = d;
        mptr = (a + 1) % 256;
    endtask

    task automatic random_read(input logic [7:0] a, input string req);
        logic k0, k1, k2;
        logic [7:0] d;
        i2c_start();
        tx_byte(8'hAA, k0);
        tx_byte(a, k1);
        i2c_start();
        tx_byte(8'hAB, k2);
        rx_byte(1'b0, d);
        i2c_stop();
        chk(k0 && k1 && k2, req, {k0, k1, k2}, 3'b111);
        chk(d == mdl[a], req, d, mdl[a]);
        mptr = (a + 1) % 256;
    endtask

    task automatic current_read(input string req);
        logic k0;
        logic [7:0] d;
        i2c_start();
        tx_byte(8'hAB, k0);
        rx_byte(1'b0, d);
        i2c_stop();
        chk(k0, req, k0, 1);
        chk(d == mdl[mptr], req, d, mdl[mptr]);
        mptr = (mptr + 1) % 256;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic       ack, s;
        logic [7:0] d;
        logic [3:0] codes [4];
        codes[0] = 4'b1011; codes[1] = 4'b0010; codes[2] = 4'b1110; codes[3] = 4'b0000;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: released line, zero pointer, zero array
        chk(sda_line == 1'b1 && sda_pull == 1'b0, "R11", sda_pull, 0);
        current_read("R11");

        // R2: every DUT strap against every addressed strap
        for (int ds = 0; ds < 8; ds++) begin
            dev_strap = ds[2:0];
            for (int ms = 0; ms < 8; ms++) begin
                i2c_start();
                tx_byte({4'b1010, ms[2:0], 1'b0}, ack);
                i2c_stop();
                chk(ack == (ms == ds), "R2", ack, (ms == ds));
            end
        end
        dev_strap = 3'b101;

        // R2: wrong device code gives no ack and a silent line afterwards
        for (int c = 0; c < 4; c++) begin
            i2c_start();
            tx_byte({codes[c], 3'b101, 1'b1}, ack);
            rx_byte(1'b0, d);
            i2c_stop();
            chk(!ack, "R2", ack, 0);
            chk(d == 8'hFF, "R2", d, 8'hFF);
        end

        // R3, R4: byte writes spread over the array, ending at the last location
        for (int i = 0; i < 16; i++) begin
            byte_write(8'((i * 17) % 256), 8'((i * 37 + 11) % 256), "R3 R4");
        end

        // R7: pointer wrapped from the last location to 0
        current_read("R7");

        // R8: random reads of every written location
        for (int i = 0; i < 16; i++) begin
            random_read(8'((i * 17) % 256), "R8");
        end

        // R5: protected write acked but not stored
        wp = 1'b1;
        byte_write(8'd17, 8'hEE, "R5");
        wp = 1'b0;
        random_read(8'd17, "R5");

        // R6: extra byte after the data byte
        byte_write(8'd41, 8'h66, "R4");
        i2c_start();
        tx_byte(8'hAA, ack);
        tx_byte(8'd40, ack);
        tx_byte(8'h11, ack);
        chk(ack, "R4", ack, 1);
        tx_byte(8'h22, ack);
        i2c_stop();
        chk(!ack, "R6", ack, 0);
        mdl[40] = 8'h11;
        mptr = 41;
        current_read("R6");
        random_read(8'd40, "R4");

        // R9, R7: sequential read across the wrap point
        i2c_start();
        tx_byte(8'hAA, ack);
        tx_byte(8'd0, ack);
        i2c_start();
        tx_byte(8'hAB, ack);
        chk(ack, "R9", ack, 1);
        for (int k = 0; k < 258; k++) begin
            rx_byte(k != 257, d);
            chk(d == mdl[k % 256], "R9", d, mdl[k % 256]);
        end
        rx_byte(1'b0, d);
        chk(d == 8'hFF, "R9", d, 8'hFF);
        i2c_stop();
        mptr = 2;

        // R1: clocks without START get no ack
        m_scl = 1'b0;
        wq();
        tx_byte(8'hAA, ack);
        i2c_stop();
        chk(!ack, "R1", ack, 0);

        // R1: START in the middle of a byte restarts the sequence
        i2c_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
        current_read("R1");

        // R10: no pull change during any high clock phase
        chk(hi_changes == 0, "R10", hi_changes, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule